// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal and vertical sync, blanking and strobe signals for a raster display. Sixteen timing registers are loaded through a plain write port and set every edge of the raster. Horizontal positions are counted in units of two pixels, one count per cycle in which the pixel-pair enable is high. Vertical positions are counted in half-lines, so the vertical counter steps twice per line.

Timing writes land in a shadow bank. The shadow bank is copied into the working bank at each frame boundary. It is also copied on every cycle while the control register forces the display blank. Software can therefore set the blank bit, rewrite the timing, and clear the blank bit without the raster ever running on a half-updated set. The control register also enables each sync output, and these enables take effect at once.

Top module: `raster_timing_gen`

## Requirements
- R1: Write addresses 0 to 15 select the timing registers in this order: v_mid_front, v_blank_start, v_blank_end, v_mid_back, v_sync_end, v_sync_start, v_total, fetch_lead, h_total, h_blank_start, h_blank_end, h_sync_end, h_sync_start, h_eq_width, h_half_point, h_serr_start. Address 16 is the control register. A write to any other address changes nothing.
- R2: The horizontal counter hc starts at 0 and rises by one on each cycle with pix2_ce high. It returns to 0 after reaching h_total+1, so a line lasts h_total+2 counts. line_start is high when pix2_ce is high and hc is 0.
- R3: hsync is high when hc >= h_sync_start or hc <= h_sync_end. This window wraps across the line boundary. The output is driven only while both control bits 5 and 4 are 1; otherwise hsync stays low.
- R4: The half-line counter vc rises by one on the pix2_ce cycle where hc equals h_half_point, and again at the line wrap. At the line wrap after reaching v_total-1 it returns to 0. frame_start is high when pix2_ce is high and hc and vc are both 0.
- R5: vsync is high when vc >= v_sync_start or vc < v_sync_end. The output is driven only while both control bits 1 and 0 are 1; otherwise vsync stays low.
- R6: active is high when h_blank_end < hc < h_blank_start and v_blank_end < vc < v_blank_start, and control bit 10 (force blank) is 0.
- R7: pipe_start is high when pix2_ce is high and hc equals fetch_lead.
- R8: eq_flag is high when (vc >= v_mid_front or vc < v_mid_back) and (hc < h_eq_width or hc >= h_serr_start).
- R9: Timing writes go to a shadow bank. The working bank takes the shadow values at the line wrap that ends a frame, so they apply from the next frame_start. While control bit 10 is 1, the working bank takes the shadow values on every cycle.
- R10: rst is synchronous and active high. It clears both counters and all timing registers, and sets the control register to force blank with both sync outputs disabled.
- R11: While pix2_ce is low, both counters hold their values, and line_start, frame_start and pipe_start stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 12 | Register write data |
| pix2_ce | input | 1 | Pixel-pair count enable |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| active | output | 1 | Active-video window |
| pipe_start | output | 1 | Fetch-pipeline start strobe |
| line_start | output | 1 | First count of each line |
| frame_start | output | 1 | First count of each frame |
| eq_flag | output | 1 | Equalisation window flag |

## Verification
The hardest case to reach is a timing write that arrives mid-frame while the display is live. The bench must show that the old line length holds until the frame ends and the new one appears exactly from the next frame_start. To get there, the stimulus locks onto frame_start, writes a new h_total two counts into the frame, and then measures the spacing of line_start pulses before and after the boundary. It repeats the write with force blank set to show that the update then takes effect at once.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int NUM_TREG = 16;

  // timing register indices (address map)
  localparam int IX_V_MID_FRONT   = 0;
  localparam int IX_V_BLANK_START = 1;
  localparam int IX_V_BLANK_END   = 2;
  localparam int IX_V_MID_BACK    = 3;
  localparam int IX_V_SYNC_END    = 4;
  localparam int IX_V_SYNC_START  = 5;
  localparam int IX_V_TOTAL       = 6;
  localparam int IX_FETCH_LEAD    = 7;
  localparam int IX_H_TOTAL       = 8;
  localparam int IX_H_BLANK_START = 9;
  localparam int IX_H_BLANK_END   = 10;
  localparam int IX_H_SYNC_END    = 11;
  localparam int IX_H_SYNC_START  = 12;
  localparam int IX_H_EQ_WIDTH    = 13;
  localparam int IX_H_HALF        = 14;
  localparam int IX_H_SERR        = 15;

  localparam int CTRL_INDEX = NUM_TREG;

  // control bit positions
  localparam int BLANK_BIT = 10;
  localparam int HS_EN_HI  = 5;
  localparam int HS_EN_LO  = 4;
  localparam int VS_EN_HI  = 1;
  localparam int VS_EN_LO  = 0;
endpackage

// File: rtl/rtg_regbank.sv
module rtg_regbank
  import rtg_pkg::*;
#(
  parameter int TW = 12,
  parameter int AW = 5
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [AW-1:0]                wr_addr,
  input  logic [TW-1:0]                wr_data,
  input  logic                         frame_end,
  output logic [NUM_TREG-1:0][TW-1:0]  act_q,
  output logic                         force_blank,
  output logic                         hs_en,
  output logic                         vs_en
);
  localparam logic [AW-1:0] CTRL_ADDR = AW'(CTRL_INDEX);

  logic [NUM_TREG-1:0][TW-1:0] shd_q;
  logic                        blank_q;
  logic [1:0]                  hs_pair_q;
  logic [1:0]                  vs_pair_q;
  logic                        xfer;

  generate
    for (genvar i = 0; i < NUM_TREG; i++) begin : g_shadow
      always_ff @(posedge clk) begin
        if (rst)
          shd_q[i] <= '0;
        else if (wr_en && (wr_addr == AW'(i)))
          shd_q[i] <= wr_data;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      blank_q   <= 1'b1;
      hs_pair_q <= 2'b00;
      vs_pair_q <= 2'b00;
    end else if (wr_en && (wr_addr == CTRL_ADDR)) begin
      blank_q   <= wr_data[BLANK_BIT];
      hs_pair_q <= {wr_data[HS_EN_HI], wr_data[HS_EN_LO]};
      vs_pair_q <= {wr_data[VS_EN_HI], wr_data[VS_EN_LO]};
    end
  end

  assign xfer = frame_end | blank_q;

  always_ff @(posedge clk) begin
    if (rst)
      act_q <= '0;
    else if (xfer)
      act_q <= shd_q;
  end

  assign force_blank = blank_q;
  assign hs_en       = &hs_pair_q;
  assign vs_en       = &vs_pair_q;

  // R9
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !xfer |=> $stable(act_q));
endmodule

// File: rtl/rtg_hcount.sv
module rtg_hcount #(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce,
  input  logic [TW-1:0] h_total,
  input  logic [TW-1:0] h_half_point,
  output logic [TW-1:0] hc,
  output logic          h_wrap,
  output logic          h_half
);
  function automatic logic [TW:0] last_count(input logic [TW-1:0] tot);
    return {1'b0, tot} + (TW+1)'(1);
  endfunction

  logic [TW:0] h_last;

  assign h_last = last_count(h_total);
  assign h_wrap = ce && ({1'b0, hc} >= h_last);
  assign h_half = ce && (hc == h_half_point);

  always_ff @(posedge clk) begin
    if (rst)
      hc <= '0;
    else if (ce)
      hc <= h_wrap ? '0 : hc + TW'(1);
  end

  // R2
  hwrap_chk: assert property (@(posedge clk) disable iff (rst)
    h_wrap |=> (hc == '0));
  // R2
  hstep_chk: assert property (@(posedge clk) disable iff (rst)
    (ce && !h_wrap) |=> (hc == $past(hc) + TW'(1)));
  // R11
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(hc));
endmodule

// File: rtl/rtg_vcount.sv
module rtg_vcount #(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          h_wrap,
  input  logic          h_half,
  input  logic [TW-1:0] v_total,
  output logic [TW-1:0] vc,
  output logic          frame_end
);
  function automatic logic at_last(input logic [TW-1:0] c, input logic [TW-1:0] tot);
    return ({1'b0, c} + (TW+1)'(1)) >= {1'b0, tot};
  endfunction

  logic v_last;
  logic v_adv;

  assign v_last    = at_last(vc, v_total);
  assign v_adv     = h_wrap | h_half;
  assign frame_end = h_wrap && v_last;

  always_ff @(posedge clk) begin
    if (rst)
      vc <= '0;
    else if (frame_end)
      vc <= '0;
    else if (v_adv && !v_last)
      vc <= vc + TW'(1);
  end

  // R4
  vwrap_chk: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> (vc == '0));
  // R4
  vidle_chk: assert property (@(posedge clk) disable iff (rst)
    !v_adv |=> $stable(vc));
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int TW = 12,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [TW-1:0] wr_data,
  input  logic          pix2_ce,
  output logic          hsync,
  output logic          vsync,
  output logic          active,
  output logic          pipe_start,
  output logic          line_start,
  output logic          frame_start,
  output logic          eq_flag
);
  // window helpers
  function automatic logic win_wrap_incl(input logic [TW-1:0] c, s, e);
    return (c >= s) || (c <= e);
  endfunction
  function automatic logic win_wrap_excl(input logic [TW-1:0] c, s, e);
    return (c >= s) || (c < e);
  endfunction
  function automatic logic win_open(input logic [TW-1:0] c, lo, hi);
    return (c > lo) && (c < hi);
  endfunction

  logic [NUM_TREG-1:0][TW-1:0] act;
  logic          force_blank, hs_en, vs_en;
  logic [TW-1:0] hc, vc;
  logic          h_wrap, h_half, frame_end;

  // named internal events
  logic hs_raw, vs_raw, h_act, v_act, eq_v, eq_h;

  rtg_regbank #(.TW(TW), .AW(AW)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .frame_end   (frame_end),
    .act_q       (act),
    .force_blank (force_blank),
    .hs_en       (hs_en),
    .vs_en       (vs_en)
  );

  rtg_hcount #(.TW(TW)) u_hcnt (
    .clk          (clk),
    .rst          (rst),
    .ce           (pix2_ce),
    .h_total      (act[IX_H_TOTAL]),
    .h_half_point (act[IX_H_HALF]),
    .hc           (hc),
    .h_wrap       (h_wrap),
    .h_half       (h_half)
  );

  rtg_vcount #(.TW(TW)) u_vcnt (
    .clk       (clk),
    .rst       (rst),
    .h_wrap    (h_wrap),
    .h_half    (h_half),
    .v_total   (act[IX_V_TOTAL]),
    .vc        (vc),
    .frame_end (frame_end)
  );

  assign hs_raw = win_wrap_incl(hc, act[IX_H_SYNC_START], act[IX_H_SYNC_END]);
  assign vs_raw = win_wrap_excl(vc, act[IX_V_SYNC_START], act[IX_V_SYNC_END]);
  assign h_act  = win_open(hc, act[IX_H_BLANK_END], act[IX_H_BLANK_START]);
  assign v_act  = win_open(vc, act[IX_V_BLANK_END], act[IX_V_BLANK_START]);
  assign eq_v   = win_wrap_excl(vc, act[IX_V_MID_FRONT], act[IX_V_MID_BACK]);
  assign eq_h   = (hc < act[IX_H_EQ_WIDTH]) || (hc >= act[IX_H_SERR]);

  assign hsync       = hs_raw & hs_en;
  assign vsync       = vs_raw & vs_en;
  assign active      = h_act & v_act & ~force_blank;
  assign pipe_start  = pix2_ce & (hc == act[IX_FETCH_LEAD]);
  assign line_start  = pix2_ce & (hc == '0);
  assign frame_start = line_start & (vc == '0);
  assign eq_flag     = eq_v & eq_h;

  // R2
  line_gap_chk: assert property (@(posedge clk) disable iff (rst)
    line_start |=> !line_start);
  // R4
  frame_line_chk: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> (hc == '0));
endmodule

// File: tb/tb_raster_timing_gen.sv
module tb_raster_timing_gen;
  logic       clk = 1'b0;
  logic       rst;
  logic       wr_en;
  logic [4:0] wr_addr;
  logic [11:0] wr_data;
  logic       pix2_ce;
  logic       hsync, vsync, active, pipe_start, line_start, frame_start, eq_flag;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  raster_timing_gen dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pix2_ce(pix2_ce), .hsync(hsync), .vsync(vsync), .active(active),
    .pipe_start(pipe_start), .line_start(line_start), .frame_start(frame_start),
    .eq_flag(eq_flag)
  );

  // timing program: line of 8 counts, frame of 5 lines (10 half-lines)
  localparam logic [11:0] PROG [16] = '{
    12'd7, 12'd8, 12'd3, 12'd3, 12'd2, 12'd8, 12'd10, 12'd1,
    12'd6, 12'd6, 12'd2, 12'd1, 12'd7, 12'd1, 12'd4, 12'd6
  };

  // {t in frame[12:7], expected {hs,vs,act,pipe,ls,fs,eq}}
  localparam int NV = 13;
  localparam logic [12:0] VEC [NV] = '{
    {6'd0,  7'b1100111}, {6'd1,  7'b1101000}, {6'd2,  7'b0100000},
    {6'd6,  7'b0100001}, {6'd7,  7'b1100001}, {6'd9,  7'b1001000},
    {6'd19, 7'b0010000}, {6'd21, 7'b0010000}, {6'd22, 7'b0000000},
    {6'd29, 7'b0010000}, {6'd30, 7'b0000001}, {6'd32, 7'b1100101},
    {6'd35, 7'b0100000}
  };

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [11:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_frame();
    int g = 0;
    do begin @(negedge clk); g++; end while (!frame_start && g < 500);
  endtask

  task automatic measure_line(output int n);
    int g = 0;
    @(negedge clk);
    while (!line_start && g < 100) begin @(negedge clk); g++; end
    n = 0;
    do begin @(negedge clk); n++; end while (!line_start && n < 100);
  endtask

  task automatic walk_table();
    int j = 0;
    wait_frame();
    for (int t = 0; t < 40; t++) begin
      if (t > 0) @(negedge clk);
      if (j < NV && int'(VEC[j][12:7]) == t) begin
        check("R3 hsync",       hsync,       VEC[j][6]);
        check("R5 vsync",       vsync,       VEC[j][5]);
        check("R6 active",      active,      VEC[j][4]);
        check("R7 pipe_start",  pipe_start,  VEC[j][3]);
        check("R2 line_start",  line_start,  VEC[j][2]);
        check("R4 frame_start", frame_start, VEC[j][1]);
        check("R8 eq_flag",     eq_flag,     VEC[j][0]);
        j++;
      end
    end
  endtask

  task automatic count_highs(output int hs, output int vs, output int ac);
    hs = 0; vs = 0; ac = 0;
    for (int k = 0; k < 48; k++) begin
      @(negedge clk);
      hs += int'(hsync); vs += int'(vsync); ac += int'(active);
    end
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, hs, vs, ac, diffs;
    logic [3:0] held;
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; pix2_ce = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    check("R10 hsync in reset", hsync, 0);
    check("R10 vsync in reset", vsync, 0);
    check("R10 active in reset", active, 0);
    check("R10 frame_start at zero counts", frame_start, 1);
    rst = 1'b0;

    for (int i = 0; i < 16; i++) wr(5'(i), PROG[i]);
    wr(5'd16, 12'h033);
    walk_table();

    // R1 writes to unmapped addresses change nothing
    wr(5'd20, 12'h000);
    wr(5'd17, 12'h000);
    wr(5'd31, 12'hfff);
    measure_line(n);
    check("R1 line length after unmapped writes", n, 8);
    walk_table();

    // R3 / R5 sync enable pairs
    wr(5'd16, 12'h013);
    count_highs(hs, vs, ac);
    check("R3 hsync held low with pair incomplete", hs, 0);
    check("R5 vsync present", int'(vs > 0), 1);
    wr(5'd16, 12'h031);
    count_highs(hs, vs, ac);
    check("R5 vsync held low with pair incomplete", vs, 0);
    check("R3 hsync present", int'(hs > 0), 1);

    // R6 force blank
    wr(5'd16, 12'h433);
    count_highs(hs, vs, ac);
    check("R6 active low under force blank", ac, 0);
    check("R6 syncs still run under force blank", int'(hs > 0), 1);
    wr(5'd16, 12'h033);
    count_highs(hs, vs, ac);
    check("R6 active returns", int'(ac > 0), 1);

    // R9 mid-frame write waits for frame boundary
    wait_frame();
    wr(5'd8, 12'd8);
    measure_line(n);
    check("R9 old line length kept in frame", n, 8);
    wait_frame();
    measure_line(n);
    check("R9 new line length after frame_start", n, 10);
    // R9 immediate load while blanked
    wr(5'd16, 12'h433);
    wr(5'd8, 12'd6);
    measure_line(n);
    check("R9 blanked write loads at once", n, 8);
    wr(5'd16, 12'h033);
    walk_table();

    // R11 count enable low
    @(negedge clk);
    pix2_ce = 1'b0;
    @(negedge clk);
    held = {hsync, vsync, active, eq_flag};
    diffs = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if ({hsync, vsync, active, eq_flag} != held) diffs++;
      if (line_start || frame_start || pipe_start) diffs++;
    end
    check("R11 outputs hold and strobes low", diffs, 0);
    pix2_ce = 1'b1;
    measure_line(n);
    check("R11 line length after stall", n, 8);

    // R10 reset mid-run
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R10 active after reset", active, 0);
    check("R10 hsync after reset", hsync, 0);
    check("R10 frame_start after reset", frame_start, 1);
    rst = 1'b0;
    measure_line(n);
    check("R10 timing registers cleared", n, 2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule